// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block copies memory to memory under the control of a circular list of 16-byte descriptors held in system memory. Software fills a descriptor with a source address, a destination address, a byte count and two flags, sets its valid bit and pulses `start`. The engine fetches the descriptor at its next-descriptor pointer. A descriptor whose valid bit is clear means the ring is empty, and the engine goes idle. A valid descriptor is copied in bursts of at most the configured size: each burst is read into an internal buffer and then written out. When the copy ends, the engine can rewrite the descriptor's first word with the valid bit cleared, an outcome flag and the number of bytes not transferred. It then steps to the next slot, wrapping to the ring base after the last one.

All memory traffic goes through one request/acknowledge port that moves 32-bit words, with one access outstanding at a time. The ring base, the ring length, the burst size code and the writeback enable come in as static configuration inputs. A one-cycle event tells interrupt logic that a descriptor which asked for notification has finished.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `memReq`=0, `descDoneEvt`=0 and `nextDescAddr`=0.
- R2: A `ringInit` pulse while idle sets `nextDescAddr` to `cfgRingBase`. A `start` pulse while idle makes the engine fetch the descriptor at `nextDescAddr`.
- R3: If the fetched word 0 has bit 31 (valid) clear, the engine reads only that one word, does no data access, leaves `nextDescAddr` on that slot and goes idle. A later `start` fetches the same slot again.
- R4: Descriptor layout. Word 0 (offset 0) holds the byte count in bits 26:0, valid in bit 31 and interrupt request in bit 30. Word 1 (offset 4) is source address bits 31:0. Word 2 (offset 8) is destination address bits 31:0. Word 3 (offset 12) holds source bits 47:32 in bits 31:16 and destination bits 47:32 in bits 15:0. Consecutive slots are 16 bytes apart.
- R5: A valid descriptor copies count/4 words from ascending source word addresses to ascending destination word addresses.
- R6: Data moves in chunks: the engine reads min(burst, remaining) words, then writes them, then repeats. `cfgBurstCode` values 0..5 give 16, 32, 64, 128, 256 and 512 words, value 7 gives 1 word and value 6 gives 16 words.
- R7: With `cfgWbEn`=1, on completion word 0 is rewritten as: bit 31 = 0, bit 30 = success, bit 29 = read failure, bit 28 = write failure, bit 27 = 0, bits 26:0 = bytes not written.
- R8: A read error response ends the copy at once. The writeback reports read failure with the original count minus the bytes already written, and the engine goes on to the next slot.
- R9: A write error response ends the copy at once. The writeback reports write failure with the original count minus the bytes successfully written, and the engine goes on to the next slot.
- R10: With `cfgWbEn`=0 the descriptor is never written. The data copy, the ring step and the event still take place.
- R11: After the slot with index `cfgRingCount`-1, the pointer returns to `cfgRingBase`.
- R12: A valid descriptor with count 0 makes no data access and is written back as success with residue 0 (word 0x40000000).
- R13: `descDoneEvt` is high for exactly one cycle per completed descriptor that had bit 30 set, and never for one that did not.
- R14: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until the cycle in which `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRingBase | input | 64 | Byte address of ring slot 0 |
| cfgRingCount | input | CNT_W | Number of slots in the ring |
| cfgBurstCode | input | 3 | Maximum chunk size code |
| cfgWbEn | input | 1 | Enables status writeback into word 0 |
| ringInit | input | 1 | Pulse: move the descriptor pointer to the ring base |
| start | input | 1 | Pulse: begin fetching at the descriptor pointer |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 64 | Byte address of the 32-bit word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access completed (one cycle) |
| memErr | input | 1 | Error flag, valid with memAck |
| memRdata | input | 32 | Read data, valid with memAck |
| busy | output | 1 | Engine is walking the ring |
| descDoneEvt | output | 1 | One-cycle event: an interrupt-requesting descriptor finished |
| nextDescAddr | output | 64 | Address of the descriptor to be fetched next |

## Verification
On every cycle, the in-module assertions guard the memory handshake (a pending request stays stable), the single-cycle width of the completion event, the chunk buffer bounds, the rule that a write never precedes the read that filled its word, the rule that the residue never underflows, and the mutual exclusion of the two failure flags. Only the directed scenarios can show the end-to-end results: the copied data, the exact writeback words after read or write errors, the chunk lengths for each burst code, the stop at an invalid slot with the restart that follows, the wrap back to the base, and the 48-bit address assembly. The bench's memory model also counts any request that changes before it is acknowledged.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int SIZE_W     = 27;
  localparam int PTR_W      = 48;
  localparam int DESC_BYTES = 16;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST, SEL_WB} addrSel_e;

  typedef struct packed {
    logic       ringRewind;
    logic       ringStep;
    logic       capDesc;
    logic [1:0] wordIdx;
    logic       chunkBegin;
    logic       rdBeat;
    logic       wrBeat;
    logic       rdFail;
    logic       wrFail;
    addrSel_e   addrSel;
  } dpCtl_t;

  // words per chunk for a burst code; code 6 is unassigned and behaves as code 0
  function automatic logic [31:0] burstWords(input logic [2:0] code);
    case (code)
      3'd7:    return 32'd1;
      3'd6:    return 32'd16;
      default: return 32'd16 << code;
    endcase
  endfunction
endpackage

// File: rtl/rce_datapath.sv
module rce_datapath
  import rce_pkg::*;
#(
  parameter int ADDR_W          = 64,
  parameter int CNT_W           = 12,
  parameter int MAX_BURST_WORDS = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cfgRingBase,
  input  logic [CNT_W-1:0]  cfgRingCount,
  input  logic [2:0]        cfgBurstCode,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              descValid,
  output logic              intReq,
  output logic              remZero,
  output logic              rdLast,
  output logic              wrLast,
  output logic [ADDR_W-1:0] nextDescAddr
);
  localparam int BUF_AW = $clog2(MAX_BURST_WORDS);
  localparam int LEN_W  = BUF_AW + 1;
  localparam int IDX_W  = CNT_W + 1;

  logic [ADDR_W-1:0] descAddr;
  logic [CNT_W-1:0]  ringIdx;
  logic              validR, intR;
  logic [PTR_W-1:0]  srcPtr, dstPtr;
  logic [SIZE_W-1:0] remBytes;
  logic [LEN_W-1:0]  chunkLen, rdCnt, wrCnt;
  logic              rdFailF, wrFailF;
  logic [31:0]       bufMem [MAX_BURST_WORDS];

  logic [31:0]       burstRaw, burstCap, remWords, chunkNext;
  logic [IDX_W-1:0]  idxInc;
  logic              atLastSlot;
  logic [31:0]       wbWord;

  always_comb begin
    burstRaw  = burstWords(cfgBurstCode);
    burstCap  = (burstRaw > 32'(MAX_BURST_WORDS)) ? 32'(MAX_BURST_WORDS) : burstRaw;
    remWords  = 32'(remBytes[SIZE_W-1:2]);
    chunkNext = (remWords < burstCap) ? remWords : burstCap;
  end

  assign idxInc     = IDX_W'(ringIdx) + IDX_W'(1);
  assign atLastSlot = (idxInc >= IDX_W'(cfgRingCount));

  // ring pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      ringIdx  <= '0;
    end else if (ctl.ringRewind) begin
      descAddr <= cfgRingBase;
      ringIdx  <= '0;
    end else if (ctl.ringStep) begin
      if (atLastSlot) begin
        descAddr <= cfgRingBase;
        ringIdx  <= '0;
      end else begin
        descAddr <= descAddr + ADDR_W'(DESC_BYTES);
        ringIdx  <= idxInc[CNT_W-1:0];
      end
    end
  end

  // descriptor capture, pointers, residue and outcome flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validR   <= 1'b0;
      intR     <= 1'b0;
      srcPtr   <= '0;
      dstPtr   <= '0;
      remBytes <= '0;
      rdFailF  <= 1'b0;
      wrFailF  <= 1'b0;
      chunkLen <= '0;
      rdCnt    <= '0;
      wrCnt    <= '0;
    end else begin
      if (ctl.capDesc) begin
        case (ctl.wordIdx)
          2'd0: begin
            validR   <= memRdata[31];
            intR     <= memRdata[30];
            remBytes <= memRdata[SIZE_W-1:0];
            rdFailF  <= 1'b0;
            wrFailF  <= 1'b0;
          end
          2'd1: srcPtr[31:0] <= memRdata;
          2'd2: dstPtr[31:0] <= memRdata;
          default: begin
            srcPtr[PTR_W-1:32] <= memRdata[31:16];
            dstPtr[PTR_W-1:32] <= memRdata[15:0];
          end
        endcase
      end
      if (ctl.chunkBegin) begin
        chunkLen <= chunkNext[LEN_W-1:0];
        rdCnt    <= '0;
        wrCnt    <= '0;
      end
      if (ctl.rdBeat) begin
        rdCnt  <= rdCnt + LEN_W'(1);
        srcPtr <= srcPtr + PTR_W'(4);
      end
      if (ctl.wrBeat) begin
        wrCnt    <= wrCnt + LEN_W'(1);
        dstPtr   <= dstPtr + PTR_W'(4);
        remBytes <= remBytes - SIZE_W'(4);
      end
      if (ctl.rdFail) rdFailF <= 1'b1;
      if (ctl.wrFail) wrFailF <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.rdBeat) bufMem[rdCnt[BUF_AW-1:0]] <= memRdata;
  end

  assign wbWord = {1'b0, ~(rdFailF | wrFailF), rdFailF, wrFailF, 1'b0, remBytes};

  always_comb begin
    case (ctl.addrSel)
      SEL_DESC: memAddr = descAddr + ADDR_W'({ctl.wordIdx, 2'b00});
      SEL_SRC:  memAddr = ADDR_W'(srcPtr);
      SEL_DST:  memAddr = ADDR_W'(dstPtr);
      default:  memAddr = descAddr;
    endcase
    memWdata = (ctl.addrSel == SEL_WB) ? wbWord : bufMem[wrCnt[BUF_AW-1:0]];
  end

  assign descValid    = validR;
  assign intReq       = intR;
  assign remZero      = (remBytes[SIZE_W-1:2] == '0);
  assign rdLast       = (rdCnt == chunkLen - LEN_W'(1));
  assign wrLast       = (wrCnt == chunkLen - LEN_W'(1));
  assign nextDescAddr = descAddr;

  AST_RD_IN_CHUNK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdBeat |-> (rdCnt < chunkLen)) else $error("read beat beyond chunk"); // R6
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBeat |-> (wrCnt < rdCnt)) else $error("write of unread word"); // R5
  AST_REM_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBeat |-> (remBytes >= SIZE_W'(4))) else $error("residue underflow"); // R7
  AST_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdFailF && wrFailF)) else $error("both failure flags set"); // R7
endmodule

// File: rtl/rce_ctrl.sv
module rce_ctrl
  import rce_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   ringInit,
  input  logic   cfgWbEn,
  input  logic   memAck,
  input  logic   memErr,
  input  logic   descValid,
  input  logic   intReq,
  input  logic   remZero,
  input  logic   rdLast,
  input  logic   wrLast,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   busy,
  output logic   descDoneEvt
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_CHUNK, ST_READ, ST_WRITE, ST_FINISH, ST_WBACK
  } state_e;

  state_e     state, stateN;
  logic [1:0] fIdx, fIdxN;
  logic       stepNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      fIdx  <= '0;
    end else begin
      state <= stateN;
      fIdx  <= fIdxN;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = SEL_DESC;
    ctl.wordIdx = fIdx;
    memReq      = 1'b0;
    memWe       = 1'b0;
    stateN      = state;
    fIdxN       = fIdx;
    stepNow     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ringInit) ctl.ringRewind = 1'b1;
        if (start) begin
          stateN = ST_FETCH;
          fIdxN  = 2'd0;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) stateN = ST_IDLE;
          else begin
            ctl.capDesc = 1'b1;
            if (fIdx == 2'd0)      stateN = ST_CHECK;
            else if (fIdx == 2'd3) stateN = ST_CHUNK;
            else                   fIdxN  = fIdx + 2'd1;
          end
        end
      end
      ST_CHECK: begin
        if (!descValid) stateN = ST_IDLE;
        else begin
          fIdxN  = 2'd1;
          stateN = ST_FETCH;
        end
      end
      ST_CHUNK: begin
        if (remZero) stateN = ST_FINISH;
        else begin
          ctl.chunkBegin = 1'b1;
          stateN         = ST_READ;
        end
      end
      ST_READ: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_SRC;
        if (memAck) begin
          if (memErr) begin
            ctl.rdFail = 1'b1;
            stateN     = ST_FINISH;
          end else begin
            ctl.rdBeat = 1'b1;
            if (rdLast) stateN = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = SEL_DST;
        if (memAck) begin
          if (memErr) begin
            ctl.wrFail = 1'b1;
            stateN     = ST_FINISH;
          end else begin
            ctl.wrBeat = 1'b1;
            if (wrLast) stateN = ST_CHUNK;
          end
        end
      end
      ST_FINISH: begin
        if (cfgWbEn) stateN = ST_WBACK;
        else         stepNow = 1'b1;
      end
      ST_WBACK: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = SEL_WB;
        if (memAck) stepNow = 1'b1;
      end
      default: stateN = ST_IDLE;
    endcase
    if (stepNow) begin
      ctl.ringStep = 1'b1;
      stateN       = ST_FETCH;
      fIdxN        = 2'd0;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign descDoneEvt = stepNow && intReq;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    descDoneEvt |=> !descDoneEvt) else $error("completion event wider than one cycle"); // R13
  AST_STOP_ON_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !descValid) |=> (!busy && !memReq)) else $error("no stop at empty slot"); // R3
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdBeat || ctl.wrBeat) |-> descValid) else $error("data access for invalid descriptor"); // R3
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int CNT_W           = 12,
  parameter int MAX_BURST_WORDS = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       cfgRingBase,
  input  logic [CNT_W-1:0]  cfgRingCount,
  input  logic [2:0]        cfgBurstCode,
  input  logic              cfgWbEn,
  input  logic              ringInit,
  input  logic              start,
  output logic              memReq,
  output logic              memWe,
  output logic [63:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [31:0]       memRdata,
  output logic              busy,
  output logic              descDoneEvt,
  output logic [63:0]       nextDescAddr
);
  dpCtl_t ctl;
  logic   descValid, intReq, remZero, rdLast, wrLast;

  rce_ctrl u_ctrl (
    .clk, .rstN, .start, .ringInit, .cfgWbEn, .memAck, .memErr,
    .descValid, .intReq, .remZero, .rdLast, .wrLast,
    .ctl, .memReq, .memWe, .busy, .descDoneEvt
  );

  rce_datapath #(
    .ADDR_W(64), .CNT_W(CNT_W), .MAX_BURST_WORDS(MAX_BURST_WORDS)
  ) u_dp (
    .clk, .rstN, .ctl, .cfgRingBase, .cfgRingCount, .cfgBurstCode, .memRdata,
    .memAddr, .memWdata, .descValid, .intReq, .remZero, .rdLast, .wrLast,
    .nextDescAddr
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)))
    else $error("request changed before acknowledge"); // R14
endmodule

// File: tb/sim_ring_copy_engine.sv
module sim_ring_copy_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] cfgRingBase = '0;
  logic [11:0] cfgRingCount = '0;
  logic [2:0]  cfgBurstCode = '0;
  logic        cfgWbEn = 1'b1;
  logic        ringInit = 1'b0, start = 1'b0;
  logic        memReq, memWe, busy, descDoneEvt;
  logic [63:0] memAddr, nextDescAddr;
  logic [31:0] memWdata;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic [31:0] memRdata = '0;

  always #5 clk = ~clk;

  ring_copy_engine u0 (
    .clk, .rstN, .cfgRingBase, .cfgRingCount, .cfgBurstCode, .cfgWbEn,
    .ringInit, .start, .memReq, .memWe, .memAddr, .memWdata,
    .memAck, .memErr, .memRdata, .busy, .descDoneEvt, .nextDescAddr
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [0:16383];

  // memory model and traffic log
  int latCnt = 0, latSeq = 0;
  logic        errArm = 1'b0, errWe = 1'b0;
  logic [63:0] errAddr = '0;
  int dataRd = 0, dataWr = 0, descRd = 0, curRun = 0, nRuns = 0, holdErr = 0;
  int runs [0:63];
  logic [63:0] lastRdAddr = '0, lastWrAddr = '0;
  logic        pendPrev = 1'b0, pendWe = 1'b0;
  logic [63:0] pendAddr = '0;
  int irqCount = 0, irqWide = 0;
  logic        irqPrev = 1'b0;

  always @(posedge clk) begin
    logic isErr, pendNow;
    if (!rstN) begin
      memAck   <= 1'b0;
      latCnt   = 0;
      pendPrev = 1'b0;
    end else begin
      if (pendPrev && !(memReq && memAddr == pendAddr && memWe == pendWe)) holdErr++;
      pendNow = 1'b0;
      if (memAck) memAck <= 1'b0;
      else if (memReq) begin
        if (latCnt != 0) begin
          latCnt--;
          pendNow = 1'b1;
        end else begin
          latCnt = latSeq;
          latSeq = (latSeq + 1) % 3;
          isErr  = errArm && memAddr == errAddr && memWe == errWe;
          memAck <= 1'b1;
          memErr <= isErr;
          if (memWe) begin
            if (!isErr) mem[memAddr[15:2]] = memWdata;
          end else memRdata <= isErr ? 32'hDEAD_BEEF : mem[memAddr[15:2]];
          if (memAddr[15:0] >= 16'h1000) begin
            if (memWe) begin
              dataWr++;
              lastWrAddr = memAddr;
              if (curRun != 0 && nRuns < 64) begin
                runs[nRuns] = curRun;
                nRuns++;
              end
              curRun = 0;
            end else begin
              dataRd++;
              curRun++;
              lastRdAddr = memAddr;
            end
          end else if (!memWe) descRd++;
        end
      end
      pendPrev = pendNow;
      pendAddr = memAddr;
      pendWe   = memWe;
      if (descDoneEvt) irqCount++;
      if (descDoneEvt && irqPrev) irqWide++;
      irqPrev = descDoneEvt;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < 16384; i++) mem[i] = 32'h0;
    dataRd = 0; dataWr = 0; descRd = 0; curRun = 0; nRuns = 0;
    errArm = 1'b0;
  endtask

  task automatic putDesc(input logic [63:0] a, input logic [31:0] w0,
                         input logic [47:0] src, input logic [47:0] dst);
    mem[a[15:2]]     = w0;
    mem[a[15:2] + 1] = src[31:0];
    mem[a[15:2] + 2] = dst[31:0];
    mem[a[15:2] + 3] = {src[47:32], dst[47:32]};
  endtask

  task automatic fillSrc(input logic [15:0] a, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) mem[a[15:2] + i] = seed + 32'(i) * 32'h0101_0103;
  endtask

  task automatic doInit(input logic [63:0] base, input logic [11:0] cnt);
    @(negedge clk);
    cfgRingBase  = base;
    cfgRingCount = cnt;
    ringInit     = 1'b1;
    @(negedge clk);
    ringInit     = 1'b0;
  endtask

  task automatic runEngine(input string tag);
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " engine returned to idle"}, 64'(busy), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 memReq after reset", 64'(memReq), 64'd0);
    chk("R1 descDoneEvt after reset", 64'(descDoneEvt), 64'd0);
    chk("R1 nextDescAddr after reset", nextDescAddr, 64'd0);
  endtask

  task automatic t_basic_restart();
    logic ok;
    clearAll();
    cfgBurstCode = 3'd0;
    cfgWbEn      = 1'b1;
    fillSrc(16'h2000, 8, 32'h1111_0000);
    putDesc(64'h100, 32'hC000_0020, 48'h2000, 48'h3000);
    doInit(64'h100, 12'd4);
    chk("R2 pointer at base after ringInit", nextDescAddr, 64'h100);
    runEngine("R2");
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (mem[(16'h3000 >> 2) + i] != mem[(16'h2000 >> 2) + i]) ok = 1'b0;
    chk("R5 copied data equals source", 64'(ok), 64'd1);
    chk("R5 data read/write counts", {32'(dataRd), 32'(dataWr)}, {32'd8, 32'd8});
    chk("R7 writeback word success", 64'(mem[16'h100 >> 2]), 64'h4000_0000);
    chk("R3 stopped at empty slot", nextDescAddr, 64'h110);
    chk("R13 one event for interrupt descriptor", 64'(irqCount), 64'd1);
    // empty slot: start again reads one word only
    dataRd = 0; dataWr = 0; descRd = 0;
    runEngine("R3");
    chk("R3 empty slot read once, no data", {32'(descRd), 32'(dataRd + dataWr)}, {32'd1, 32'd0});
    chk("R3 pointer stays on empty slot", nextDescAddr, 64'h110);
    // fill the slot and restart
    fillSrc(16'h2100, 4, 32'h2222_0000);
    putDesc(64'h110, 32'h8000_0010, 48'h2100, 48'h3100);
    runEngine("R3");
    chk("R3 restart copies refilled slot", 64'(mem[16'h3100 >> 2 + 3]), 64'(mem[16'h2100 >> 2 + 3]));
    chk("R3 restart writeback", 64'(mem[16'h110 >> 2]), 64'h4000_0000);
    chk("R3 pointer advanced", nextDescAddr, 64'h120);
    chk("R13 no event without interrupt flag", 64'(irqCount), 64'd1);
  endtask

  task automatic burstCase(input logic [2:0] code, input int words, input int nExp,
                           input int r0, input int r1, input int r2);
    logic ok;
    clearAll();
    cfgBurstCode = code;
    fillSrc(16'h4000, words, 32'h3300_0000 + 32'(code));
    putDesc(64'h400, 32'h8000_0000 | 32'(words * 4), 48'h4000, 48'h8000);
    doInit(64'h400, 12'd2);
    runEngine("R6");
    chk($sformatf("R6 code %0d chunk count", code), 64'(nRuns), 64'(nExp));
    chk($sformatf("R6 code %0d chunk lengths", code),
        {16'(runs[0]), 16'(nExp > 1 ? runs[1] : 0), 16'(nExp > 2 ? runs[2] : 0)},
        {16'(r0), 16'(r1), 16'(r2)});
    ok = 1'b1;
    for (int i = 0; i < words; i++) if (mem[(16'h8000 >> 2) + i] != mem[(16'h4000 >> 2) + i]) ok = 1'b0;
    chk($sformatf("R5 code %0d data copied", code), 64'(ok), 64'd1);
  endtask

  task automatic t_read_error();
    clearAll();
    cfgBurstCode = 3'd7;
    fillSrc(16'h2000, 16, 32'h4400_0000);
    fillSrc(16'h2400, 2, 32'h5500_0000);
    putDesc(64'h600, 32'h8000_0040, 48'h2000, 48'h3000);
    putDesc(64'h610, 32'h8000_0008, 48'h2400, 48'h3400);
    errArm = 1'b1; errWe = 1'b0; errAddr = 64'h2008;
    doInit(64'h600, 12'd8);
    runEngine("R8");
    chk("R8 read-fail writeback residue 56", 64'(mem[16'h600 >> 2]), 64'h2000_0038);
    chk("R8 words before error copied", 64'(mem[(16'h3000 >> 2) + 1]), 64'(mem[(16'h2000 >> 2) + 1]));
    chk("R8 failed word not written", 64'(mem[(16'h3000 >> 2) + 2]), 64'd0);
    chk("R8 next slot still processed", 64'(mem[16'h610 >> 2]), 64'h4000_0000);
    chk("R8 next slot data", 64'(mem[(16'h3400 >> 2) + 1]), 64'(mem[(16'h2400 >> 2) + 1]));
  endtask

  task automatic t_write_error();
    clearAll();
    cfgBurstCode = 3'd0;
    fillSrc(16'h2000, 8, 32'h6600_0000);
    putDesc(64'h700, 32'h8000_0020, 48'h2000, 48'h3000);
    errArm = 1'b1; errWe = 1'b1; errAddr = 64'h3004;
    doInit(64'h700, 12'd8);
    runEngine("R9");
    chk("R9 write-fail writeback residue 28", 64'(mem[16'h700 >> 2]), 64'h1000_001C);
    chk("R9 first word written", 64'(mem[16'h3000 >> 2]), 64'(mem[16'h2000 >> 2]));
    chk("R9 nothing written after error", {32'(mem[(16'h3000 >> 2) + 1]), 32'(mem[(16'h3000 >> 2) + 2])}, 64'd0);
    chk("R9 write attempts", 64'(dataWr), 64'd2);
  endtask

  task automatic t_no_writeback();
    int irq0;
    clearAll();
    irq0    = irqCount;
    cfgWbEn = 1'b0;
    fillSrc(16'h2000, 2, 32'h7700_0000);
    putDesc(64'h800, 32'hC000_0008, 48'h2000, 48'h3000);
    doInit(64'h800, 12'd4);
    runEngine("R10");
    chk("R10 descriptor untouched", 64'(mem[16'h800 >> 2]), 64'hC000_0008);
    chk("R10 data still copied", 64'(mem[(16'h3000 >> 2) + 1]), 64'(mem[(16'h2000 >> 2) + 1]));
    chk("R10 pointer stepped", nextDescAddr, 64'h810);
    chk("R13 event without writeback", 64'(irqCount - irq0), 64'd1);
    cfgWbEn = 1'b1;
  endtask

  task automatic t_wrap();
    clearAll();
    for (int s = 0; s < 4; s++) begin
      fillSrc(16'h2000 + 16'(s * 16), 1, 32'h8800_0000 + 32'(s));
      putDesc(64'h200 + 64'(s * 16), 32'h8000_0004, 48'h2000 + 48'(s * 16), 48'h3000 + 48'(s * 16));
    end
    doInit(64'h200, 12'd3);
    runEngine("R11");
    chk("R11 slots 0..2 completed",
        {16'(mem[16'h200 >> 2] >> 16), 16'(mem[16'h210 >> 2] >> 16), 16'(mem[16'h220 >> 2] >> 16)},
        {16'h4000, 16'h4000, 16'h4000});
    chk("R11 slot past ring end untouched", 64'(mem[16'h230 >> 2]), 64'h8000_0004);
    chk("R11 pointer wrapped to base", nextDescAddr, 64'h200);
  endtask

  task automatic t_zero_len();
    clearAll();
    putDesc(64'h900, 32'h8000_0000, 48'h2000, 48'h3000);
    doInit(64'h900, 12'd4);
    runEngine("R12");
    chk("R12 zero-length writeback", 64'(mem[16'h900 >> 2]), 64'h4000_0000);
    chk("R12 no data access", 64'(dataRd + dataWr), 64'd0);
  endtask

  task automatic t_high_addr();
    clearAll();
    fillSrc(16'h2000, 1, 32'h9900_0000);
    putDesc(64'hA00, 32'h8000_0004, 48'h0001_0000_2000, 48'h0002_0000_3000);
    doInit(64'hA00, 12'd4);
    runEngine("R4");
    chk("R4 source address assembled", lastRdAddr, 64'h0001_0000_2000);
    chk("R4 destination address assembled", lastWrAddr, 64'h0002_0000_3000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_restart();
    burstCase(3'd0, 40, 3, 16, 16, 8);
    burstCase(3'd7, 3, 3, 1, 1, 1);
    burstCase(3'd2, 100, 2, 64, 36, 0);
    burstCase(3'd6, 20, 2, 16, 4, 0);
    t_read_error();
    t_write_error();
    t_no_writeback();
    t_wrap();
    t_zero_len();
    t_high_addr();
    chk("R14 requests held until acknowledged", 64'(holdErr), 64'd0);
    chk("R13 event never wider than one cycle", 64'(irqWide), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule